// File: doc/BRIEF.md
# PWM Channel Status Flag Register

This block holds the eight-bit interrupt and status word of one channel in a chained multi-channel PWM controller. It watches the channel's two PWM outputs, the channel's end-of-cycle pulse, the run pulse from the preceding channel in the ring, and two external event strobes. From these it latches sticky flags that software reads through a read port and clears by writing ones. An interrupt request is formed from the latched flags and an enable mask that is supplied as a plain input.

Channels are wired in a ring for synchronisation. Each channel's `prev_run` comes from the channel before it, and the first channel takes the last channel's run pulse. A small state machine, `pwm_sync_monitor`, decides when the alignment check is live. Its states are `SYNC_OFF`, where the channel runs free and no check is made, and `SYNC_ARMED`, where auto-run is in force and the check is made. There are two transitions. `SYNC_OFF -> SYNC_ARMED` is taken on any clock edge with `auto_run` high. `SYNC_ARMED -> SYNC_OFF` is taken on any clock edge with `auto_run` low.

Flag word layout: bit 7 output-B activity, bit 6 output-A activity, bit 5 sync error, bit 4 event B, bit 3 event A, bits 2:1 generator status (read-only), bit 0 end of cycle.

Top module: `pwm_status_flags`

## Requirements
- R1: After reset, bits 7:3 and bit 0 of `rd_data` read 0 and `irq` is low. Bits 2:1 then show `gen_state`.
- R2: Bit 6 becomes 1 on a clock edge where `out_a` differs from its value at the previous edge. A rise and a fall both count. Holding a level sets nothing.
- R3: Bit 7 becomes 1 on a clock edge where `out_b` differs from its value at the previous edge, in either direction.
- R4: In state `SYNC_ARMED` with `auto_run` high, bit 5 becomes 1 on an edge where exactly one of `cycle_end` and `prev_run` is high. An edge where both are high sets nothing.
- R5: While `auto_run` is low, bit 5 is never set. On the first edge with `auto_run` high, the monitor is still in `SYNC_OFF`, so no sync check is made on that edge.
- R6: Bit 3 becomes 1 on an edge with `evt_a` high, and bit 4 becomes 1 on an edge with `evt_b` high.
- R7: Bit 0 becomes 1 on an edge with `cycle_end` high, whatever the value of `auto_run`.
- R8: An edge with `wr_en` high clears every flag whose `wr_data` bit is 1. A flag whose `wr_data` bit is 0 keeps its value.
- R9: If a flag is set by hardware and cleared by a write on the same edge, the flag ends at 1.
- R10: Bits 2:1 of `rd_data` show `gen_state[1:0]` combinationally, and writes to these bits have no effect.
- R11: `irq` is the OR of (flag AND `irq_mask`) over bits 5, 4, 3 and 0. Bits 7 and 6 never raise `irq`. Flags still latch when their mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_a | input | 1 | PWM output A of this channel |
| out_b | input | 1 | PWM output B of this channel |
| cycle_end | input | 1 | End-of-cycle / update pulse of this channel |
| prev_run | input | 1 | Run pulse from the preceding channel in the ring |
| auto_run | input | 1 | Auto-run (slave) mode enable |
| evt_a | input | 1 | External event strobe, input block A |
| evt_b | input | 1 | External event strobe, input block B |
| gen_state | input | 2 | Generator status shown on bits 2:1 |
| irq_mask | input | 8 | Interrupt enable mask, bit-aligned with the flag word |
| wr_en | input | 1 | Write strobe (write-one-to-clear) |
| wr_data | input | 8 | Write data; a 1 clears the matching flag |
| rd_data | output | 8 | Flag word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the sync check in its live state. The monitor must already be in `SYNC_ARMED`, which takes one edge with `auto_run` high. Only then does a lone `prev_run`, or a lone `cycle_end`, set the error flag. The stimulus first raises `auto_run` together with a lone run pulse and confirms that no flag appears on that edge. It then gives a coincident pair and each lone pulse in turn, clearing the flag between them. The race between a hardware set and a software clear is produced by driving an event strobe and a clearing write on the same edge.

// File: rtl/pwm_flag_pkg.sv
package pwm_flag_pkg;

    localparam int FLAG_W   = 8;
    localparam int GEN_W    = 2;

    localparam int BIT_EOC   = 0;
    localparam int BIT_GEN   = 1;
    localparam int BIT_EVA   = 3;
    localparam int BIT_EVB   = 4;
    localparam int BIT_SYNC  = 5;
    localparam int BIT_ACT_A = 6;
    localparam int BIT_ACT_B = 7;

    localparam int N_OUTS    = 2;

    localparam logic [FLAG_W-1:0] IRQ_SRC  = 8'b0011_1001;
    localparam logic [FLAG_W-1:0] GEN_BITS = 8'b0000_0110;

    typedef enum logic {
        SYNC_OFF   = 1'b0,
        SYNC_ARMED = 1'b1
    } sync_state_t;

endpackage

// File: rtl/pwm_edge_detect.sv
module pwm_edge_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] toggled
);

    logic [N-1:0] sig_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sig_q[i] <= 1'b0;
            end else begin
                sig_q[i] <= sig[i];
            end
        end

        assign toggled[i] = sig[i] ^ sig_q[i];
    end

endmodule

// File: rtl/pwm_sync_monitor.sv
module pwm_sync_monitor
    import pwm_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_run,
    input  logic cycle_end,
    input  logic prev_run,
    output logic sync_err
);

    sync_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_OFF:   if (auto_run)  state_d = SYNC_ARMED;
            SYNC_ARMED: if (!auto_run) state_d = SYNC_OFF;
            default:    state_d = SYNC_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYNC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sync_err = 1'b0;
        unique case (state_q)
            SYNC_OFF:   sync_err = 1'b0;
            SYNC_ARMED: sync_err = auto_run && (cycle_end ^ prev_run);
            default:    sync_err = 1'b0;
        endcase
    end

    // R4: a coincident pair never produces an error
    a_r4_aligned_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && prev_run) |-> !sync_err);

endmodule

// File: rtl/pwm_flag_cell.sv
module pwm_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end

    // R9: a hardware set always lands, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

    // R8: without a clear, a set flag stays set
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);

endmodule

// File: rtl/pwm_status_flags.sv
module pwm_status_flags
    import pwm_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_a,
    input  logic              out_b,
    input  logic              cycle_end,
    input  logic              prev_run,
    input  logic              auto_run,
    input  logic              evt_a,
    input  logic              evt_b,
    input  logic [GEN_W-1:0]  gen_state,
    input  logic [FLAG_W-1:0] irq_mask,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] rd_data,
    output logic              irq
);

    logic [N_OUTS-1:0] toggled;
    logic              sync_err;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] flags;

    pwm_edge_detect #(.N(N_OUTS)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     ({out_b, out_a}),
        .toggled (toggled)
    );

    pwm_sync_monitor u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_run  (auto_run),
        .cycle_end (cycle_end),
        .prev_run  (prev_run),
        .sync_err  (sync_err)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_EOC]   = cycle_end;
        set_vec[BIT_EVA]   = evt_a;
        set_vec[BIT_EVB]   = evt_b;
        set_vec[BIT_SYNC]  = sync_err;
        set_vec[BIT_ACT_A] = toggled[0];
        set_vec[BIT_ACT_B] = toggled[1];
        clr_vec            = wr_en ? (wr_data & ~GEN_BITS) : '0;
    end

    for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
        if (GEN_BITS[b]) begin : g_status
            assign flags[b] = gen_state[b-BIT_GEN];
        end else begin : g_sticky
            pwm_flag_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (set_vec[b]),
                .clr   (clr_vec[b]),
                .q     (flags[b])
            );
        end
    end

    assign rd_data = flags;
    assign irq     = |(flags & irq_mask & IRQ_SRC);

    // R2: output A activity lands in bit 6
    a_r2_act_a: assert property (@(posedge clk) disable iff (!rst_n)
        toggled[0] |=> rd_data[BIT_ACT_A]);

    // R3: output B activity lands in bit 7
    a_r3_act_b: assert property (@(posedge clk) disable iff (!rst_n)
        toggled[1] |=> rd_data[BIT_ACT_B]);

    // R5: with auto-run off a clear sync flag stays clear
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_run && !rd_data[BIT_SYNC]) |=> !rd_data[BIT_SYNC]);

    // R11: activity flags alone never raise the request
    a_r11_no_act_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & irq_mask & IRQ_SRC) == '0) |-> !irq);

endmodule

// File: tb/sim_pwm_status_flags.sv
module sim_pwm_status_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_a = 0, out_b = 0, cycle_end = 0, prev_run = 0, auto_run = 0;
    logic       evt_a = 0, evt_b = 0, wr_en = 0;
    logic [1:0] gen_state = 2'b00;
    logic [7:0] irq_mask = 8'h00, wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_status_flags u0 (
        .clk(clk), .rst_n(rst_n), .out_a(out_a), .out_b(out_b),
        .cycle_end(cycle_end), .prev_run(prev_run), .auto_run(auto_run),
        .evt_a(evt_a), .evt_b(evt_b), .gen_state(gen_state),
        .irq_mask(irq_mask), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        wr_en = 1; wr_data = 8'hFF;
        tick();
        wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic t_reset();
        gen_state = 2'b10;
        #1;
        check("R1 flags", rd_data & 8'hF9, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R10 status", {6'b0, rd_data[2:1]}, 8'h02);
        gen_state = 2'b01;
        #1;
        check("R10 status follows", {6'b0, rd_data[2:1]}, 8'h01);
        wr_en = 1; wr_data = 8'h06;
        tick();
        wr_en = 0; wr_data = 8'h00;
        check("R10 write ignored", {6'b0, rd_data[2:1]}, 8'h01);
        gen_state = 2'b00;
    endtask

    task automatic t_activity();
        out_a = 1; tick();
        check("R2 rise", rd_data, 8'h40);
        tick();
        wr_en = 1; wr_data = 8'h40; tick();
        wr_en = 0; wr_data = 8'h00;
        check("R2 hold no set", rd_data, 8'h00);
        out_a = 0; tick();
        check("R2 fall", rd_data, 8'h40);
        clear_all();
        out_b = 1; tick();
        check("R3 rise", rd_data, 8'h80);
        clear_all();
        out_b = 0; tick();
        check("R3 fall", rd_data, 8'h80);
        clear_all();
    endtask

    task automatic t_events();
        evt_a = 1; tick(); evt_a = 0;
        check("R6 event A", rd_data, 8'h08);
        evt_b = 1; tick(); evt_b = 0;
        check("R6 event B", rd_data, 8'h18);
        wr_en = 1; wr_data = 8'h08; tick();
        wr_en = 0; wr_data = 8'h00;
        check("R8 clear one keeps other", rd_data, 8'h10);
        wr_en = 1; wr_data = 8'h00; tick();
        wr_en = 0;
        check("R8 write zero keeps", rd_data, 8'h10);
        evt_a = 1; wr_en = 1; wr_data = 8'h08; tick();
        evt_a = 0; wr_en = 0; wr_data = 8'h00;
        check("R9 set beats clear", rd_data, 8'h18);
        clear_all();
        cycle_end = 1; tick(); cycle_end = 0;
        check("R7 end of cycle free run", rd_data, 8'h01);
        clear_all();
    endtask

    task automatic t_sync();
        prev_run = 1; tick(); prev_run = 0;
        check("R5 off no sync", rd_data, 8'h00);
        auto_run = 1; prev_run = 1; tick(); prev_run = 0;
        check("R5 first auto edge unchecked", rd_data, 8'h00);
        cycle_end = 1; prev_run = 1; tick(); cycle_end = 0; prev_run = 0;
        check("R4 aligned", rd_data, 8'h01);
        clear_all();
        prev_run = 1; tick(); prev_run = 0;
        check("R4 lone run", rd_data, 8'h20);
        clear_all();
        cycle_end = 1; tick(); cycle_end = 0;
        check("R4 lone end", rd_data, 8'h21);
        clear_all();
        auto_run = 0; tick();
        prev_run = 1; tick(); prev_run = 0;
        check("R5 disabled again", rd_data, 8'h00);
    endtask

    task automatic t_irq();
        irq_mask = 8'h00;
        evt_a = 1; tick(); evt_a = 0;
        check("R11 flag with mask off", rd_data, 8'h08);
        check("R11 irq masked", {7'b0, irq}, 8'h00);
        irq_mask = 8'h08; #1;
        check("R11 irq enabled", {7'b0, irq}, 8'h01);
        clear_all();
        irq_mask = 8'hC0;
        out_a = 1; out_b = 1; tick();
        check("R11 activity flags", rd_data, 8'hC0);
        check("R11 activity no irq", {7'b0, irq}, 8'h00);
        irq_mask = 8'h01; cycle_end = 1; tick(); cycle_end = 0;
        check("R11 eoc irq", {7'b0, irq}, 8'h01);
        clear_all();
        irq_mask = 8'h00; out_a = 0; out_b = 0; tick();
        clear_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_activity();
        t_events();
        t_sync();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule